// File: doc/BRIEF.md
# Bus-Master DMA Channel Register Front End

This block is the control face of one disk bus-master DMA channel. Software reaches a command byte, a status byte and a descriptor table base address through a small register port. The port is byte addressed and takes accesses one, two or four bytes wide. The command byte holds a run bit and a transfer direction bit.

When the run bit goes from 0 to 1, the block copies the base address into the walk pointer, which the descriptor walker starts from. If no transfer is in progress, the block also marks the channel busy and pulses a start request to the walker. When the run bit goes from 1 to 0, a transfer already in progress is not cut off. The channel stays busy until the walker reports that it is done.

The drive interrupt line passes through the block unchanged on its way to the host. Each rising edge on that line also latches an interrupt flag in the status byte.

Top module: `bmdma_regs`

## Requirements
- R1: After reset, the command, status and base address all read 0, the walk pointer is 0 and the start request is low.
- R2: The command byte (target 0) stores only bit 0 (run) and bit 3 (direction). Every other written bit reads back as 0, and `walk_dir` follows bit 3.
- R3: A command write that takes the run bit from 0 to 1 while the status busy bit (bit 0) is clear does three things. It raises `walk_start` for exactly the cycle after the write, it sets the busy bit, and it loads `walk_ptr` with the base address.
- R4: A command write whose run bit equals the stored run bit causes no start request, and `walk_ptr` keeps its value.
- R5: A command write that takes the run bit from 1 to 0 leaves the busy bit set and `walk_ptr` unchanged.
- R6: A 0-to-1 run transition while the busy bit is still set reloads `walk_ptr` from the base address, but raises no start request.
- R7: An address write (target 2) at byte offset k with size code s (0 = 1 byte, 1 = 2 bytes, 2 or 3 = 4 bytes) replaces only bytes k upward within that width. Bits 1:0 of the stored address are always 0.
- R8: An address read at byte offset k with size code s returns the address shifted right by 8*k and masked to the access width.
- R9: `host_irq` equals `drv_irq` at all times. A rising edge on `drv_irq` sets status bit 2; a falling edge leaves it unchanged.
- R10: A status write (target 1) clears bit 1 (error) and bit 2 (interrupt) where the written bit is 1. It never changes bit 0 (busy).
- R11: A `walk_done` pulse clears the busy bit. It sets the error bit only if `walk_err` is high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_en | input | 1 | Register access this cycle |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_tgt | input | 2 | 0 command, 1 status, 2 address, 3 unused (reads 0) |
| acc_off | input | 2 | Byte offset within the register |
| acc_size | input | 2 | 0 one byte, 1 two bytes, 2/3 four bytes |
| acc_wdata | input | 32 | Write data, right aligned |
| acc_rdata | output | 32 | Read data, combinational |
| walk_start | output | 1 | One-cycle start request to the descriptor walker |
| walk_ptr | output | 32 | Table address the walker begins from |
| walk_dir | output | 1 | Direction bit from the command byte |
| walk_done | input | 1 | Walker has finished the transfer |
| walk_err | input | 1 | Error qualifier sampled with walk_done |
| drv_irq | input | 1 | Interrupt line from the drive |
| host_irq | output | 1 | Interrupt line to the host |

## Verification
Read data and `host_irq` are combinational, so they are compared in the same cycle as the stimulus, a short delay after the falling edge that applied it. Register state changes at the rising edge that captures a write, and `walk_start` is a register. All of these are therefore compared at the falling edge one half cycle after that rising edge. The start request is checked again one cycle later to confirm that it has dropped. A status flag set by an interrupt edge or a done pulse is read back on the following cycle, after the edge that latches it.

// File: rtl/bmdma_regs.sv
module bmdma_regs #(
  parameter int ADDR_W = 32,
  localparam int OFF_W = $clog2(ADDR_W / 8)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_en,
  input  logic              acc_wr,
  input  logic [1:0]        acc_tgt,
  input  logic [OFF_W-1:0]  acc_off,
  input  logic [1:0]        acc_size,
  input  logic [ADDR_W-1:0] acc_wdata,
  output logic [ADDR_W-1:0] acc_rdata,
  output logic              walk_start,
  output logic [ADDR_W-1:0] walk_ptr,
  output logic              walk_dir,
  input  logic              walk_done,
  input  logic              walk_err,
  input  logic              drv_irq,
  output logic              host_irq
);

  logic              cmd_run, cmd_dir;
  logic              sts_act, sts_err, sts_int;
  logic              irq_q, start_q;
  logic [ADDR_W-1:0] base_q, ptr_q;
  logic [ADDR_W-1:0] lane_mask;

  always_comb begin
    case (acc_size)
      2'd0:    lane_mask = ADDR_W'('hFF);
      2'd1:    lane_mask = ADDR_W'('hFFFF);
      default: lane_mask = '1;
    endcase
  end

  wire [OFF_W+2:0]  shamt   = {acc_off, 3'b000};
  wire [ADDR_W-1:0] sh_mask = lane_mask << shamt;
  wire [ADDR_W-1:0] sh_data = (acc_wdata & lane_mask) << shamt;
  wire [ADDR_W-1:0] base_nx = ((base_q & ~sh_mask) | sh_data) & ~ADDR_W'(3);

  wire wr_cmd = acc_en & acc_wr & (acc_tgt == 2'd0);
  wire wr_sts = acc_en & acc_wr & (acc_tgt == 2'd1);
  wire wr_adr = acc_en & acc_wr & (acc_tgt == 2'd2);

  wire run_rise = wr_cmd & acc_wdata[0] & ~cmd_run;
  wire irq_rise = drv_irq & ~irq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_run <= 1'b0;
      cmd_dir <= 1'b0;
      sts_act <= 1'b0;
      sts_err <= 1'b0;
      sts_int <= 1'b0;
      irq_q   <= 1'b0;
      start_q <= 1'b0;
      base_q  <= '0;
      ptr_q   <= '0;
    end else begin
      irq_q   <= drv_irq;
      start_q <= run_rise & ~sts_act;
      if (wr_cmd) begin
        cmd_run <= acc_wdata[0];
        cmd_dir <= acc_wdata[3];
      end
      if (wr_adr) base_q <= base_nx;
      if (run_rise) ptr_q <= base_q;
      if (run_rise) sts_act <= 1'b1;
      else if (walk_done) sts_act <= 1'b0;
      sts_err <= (sts_err & ~(wr_sts & acc_wdata[1])) | (walk_done & walk_err);
      sts_int <= (sts_int & ~(wr_sts & acc_wdata[2])) | irq_rise;
    end
  end

  always_comb begin
    case (acc_tgt)
      2'd0:    acc_rdata = ADDR_W'({cmd_dir, 2'b00, cmd_run});
      2'd1:    acc_rdata = ADDR_W'({sts_int, sts_err, sts_act});
      2'd2:    acc_rdata = (base_q >> shamt) & lane_mask;
      default: acc_rdata = '0;
    endcase
  end

  assign walk_start = start_q;
  assign walk_ptr   = ptr_q;
  assign walk_dir   = cmd_dir;
  assign host_irq   = drv_irq;

endmodule

module bmdma_regs_sva #(
  parameter int ADDR_W = 32,
  localparam int OFF_W = $clog2(ADDR_W / 8)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              acc_en,
  input logic              acc_wr,
  input logic [1:0]        acc_tgt,
  input logic [OFF_W-1:0]  acc_off,
  input logic [ADDR_W-1:0] acc_wdata,
  input logic [ADDR_W-1:0] acc_rdata,
  input logic              walk_start,
  input logic [ADDR_W-1:0] walk_ptr,
  input logic [ADDR_W-1:0] base_q,
  input logic              sts_act,
  input logic              sts_int,
  input logic              drv_irq,
  input logic              walk_done
);

  p_cmd_mask_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && !acc_wr && acc_tgt == 2'd0) |-> ((acc_rdata & ~ADDR_W'(9)) == '0));

  p_start_src_r3: assert property (@(posedge clk) disable iff (!rst_n)
    walk_start |-> $past(acc_en && acc_wr && acc_tgt == 2'd0 && acc_wdata[0]));

  p_start_ptr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    walk_start |-> (walk_ptr == base_q && sts_act));

  p_addr_align_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && !acc_wr && acc_tgt == 2'd2 && acc_off == '0) |-> (acc_rdata[1:0] == 2'b00));

  p_irq_latch_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drv_irq) |=> sts_int);

  p_done_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (walk_done && !(acc_en && acc_wr && acc_tgt == 2'd0)) |=> !sts_act);

endmodule

bind bmdma_regs bmdma_regs_sva #(.ADDR_W(ADDR_W)) u_sva (.*);

// File: tb/bmdma_regs_bench.sv
module bmdma_regs_bench;

  typedef struct {
    int          kind;
    logic [31:0] exp;
    string       name;
  } item_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_en = 1'b0, acc_wr = 1'b0;
  logic [1:0]  acc_tgt = '0, acc_off = '0, acc_size = '0;
  logic [31:0] acc_wdata = '0;
  logic [31:0] acc_rdata;
  logic        walk_start, walk_dir, host_irq;
  logic [31:0] walk_ptr;
  logic        walk_done = 1'b0, walk_err = 1'b0, drv_irq = 1'b0;

  int checks = 0, errors = 0;
  bit finished = 0;
  item_t q[$];

  always #2 clk = ~clk;

  bmdma_regs u_bmdma_regs (
    .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_wr(acc_wr),
    .acc_tgt(acc_tgt), .acc_off(acc_off), .acc_size(acc_size),
    .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
    .walk_start(walk_start), .walk_ptr(walk_ptr), .walk_dir(walk_dir),
    .walk_done(walk_done), .walk_err(walk_err),
    .drv_irq(drv_irq), .host_irq(host_irq)
  );

  initial begin : monitor
    item_t it;
    logic [31:0] act;
    forever begin
      wait (q.size() > 0);
      it = q.pop_front();
      case (it.kind)
        0: act = acc_rdata;
        1: act = {31'b0, walk_start};
        2: act = walk_ptr;
        3: act = {31'b0, host_irq};
        default: act = {31'b0, walk_dir};
      endcase
      checks++;
      if (act !== it.exp) begin
        errors++;
        $display("FAIL %s: actual %h expected %h", it.name, act, it.exp);
      end
    end
  end

  task automatic expect_item(int kind, logic [31:0] exp, string name);
    item_t it;
    it.kind = kind; it.exp = exp; it.name = name;
    #1;
    q.push_back(it);
    wait (q.size() == 0);
  endtask

  task automatic wr(logic [1:0] tgt, logic [1:0] off, logic [1:0] sz, logic [31:0] d);
    @(negedge clk);
    acc_en = 1; acc_wr = 1; acc_tgt = tgt; acc_off = off; acc_size = sz; acc_wdata = d;
    @(negedge clk);
    acc_en = 0; acc_wr = 0;
  endtask

  task automatic rd(logic [1:0] tgt, logic [1:0] off, logic [1:0] sz, logic [31:0] exp, string name);
    @(negedge clk);
    acc_en = 1; acc_wr = 0; acc_tgt = tgt; acc_off = off; acc_size = sz;
    expect_item(0, exp, name);
    acc_en = 0;
  endtask

  task automatic done_pulse(logic e);
    @(negedge clk);
    walk_done = 1; walk_err = e;
    @(negedge clk);
    walk_done = 0; walk_err = 0;
  endtask

  initial begin : watchdog
    #(200000 * 4);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : driver
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    rd(2'd0, 0, 2, 32'h0, "R1 command");
    rd(2'd1, 0, 2, 32'h0, "R1 status");
    rd(2'd2, 0, 2, 32'h0, "R1 address");
    expect_item(2, 32'h0, "R1 walk_ptr");
    expect_item(1, 32'h0, "R1 walk_start");
    // R7 partial address writes
    wr(2'd2, 0, 2, 32'h12345677);
    rd(2'd2, 0, 2, 32'h12345674, "R7 full write low bits");
    wr(2'd2, 2, 1, 32'h0000ABCD);
    wr(2'd2, 1, 0, 32'h000000FF);
    wr(2'd2, 0, 0, 32'h00000003);
    rd(2'd2, 0, 2, 32'hABCDFF00, "R7 byte lanes");
    // R8 shifted reads
    rd(2'd2, 2, 0, 32'h000000CD, "R8 byte at 2");
    rd(2'd2, 1, 1, 32'h0000CDFF, "R8 half at 1");
    rd(2'd2, 3, 1, 32'h000000AB, "R8 half at 3");
    // R2 command masking
    wr(2'd0, 0, 0, 32'hF6);
    rd(2'd0, 0, 0, 32'h00, "R2 mask zero");
    wr(2'd0, 0, 0, 32'hFE);
    rd(2'd0, 0, 0, 32'h08, "R2 direction kept");
    expect_item(4, 32'h1, "R2 walk_dir");
    expect_item(1, 32'h0, "R2 no start");
    // R3 start rise
    wr(2'd0, 0, 0, 32'h09);
    expect_item(1, 32'h1, "R3 start pulse");
    expect_item(2, 32'hABCDFF00, "R3 pointer load");
    @(negedge clk);
    expect_item(1, 32'h0, "R3 pulse one cycle");
    rd(2'd1, 0, 0, 32'h01, "R3 busy set");
    // R4 unchanged run bit
    wr(2'd2, 0, 2, 32'h00001000);
    wr(2'd0, 0, 0, 32'h01);
    expect_item(1, 32'h0, "R4 no start");
    expect_item(2, 32'hABCDFF00, "R4 pointer kept");
    rd(2'd0, 0, 0, 32'h01, "R4 command");
    // R5 stop while busy
    wr(2'd0, 0, 0, 32'h00);
    rd(2'd1, 0, 0, 32'h01, "R5 busy held");
    expect_item(2, 32'hABCDFF00, "R5 pointer kept");
    // R6 restart while busy
    wr(2'd0, 0, 0, 32'h01);
    expect_item(1, 32'h0, "R6 no start");
    expect_item(2, 32'h00001000, "R6 pointer reload");
    // R11 done with error
    done_pulse(1'b1);
    rd(2'd1, 0, 0, 32'h02, "R11 done with error");
    // R10 write one to clear
    wr(2'd1, 0, 0, 32'h01);
    rd(2'd1, 0, 0, 32'h02, "R10 bit0 write no effect");
    wr(2'd1, 0, 0, 32'h02);
    rd(2'd1, 0, 0, 32'h00, "R10 error cleared");
    wr(2'd0, 0, 0, 32'h00);
    wr(2'd0, 0, 0, 32'h01);
    expect_item(1, 32'h1, "R3 second start");
    wr(2'd1, 0, 0, 32'h07);
    rd(2'd1, 0, 0, 32'h01, "R10 busy survives clear");
    done_pulse(1'b0);
    rd(2'd1, 0, 0, 32'h00, "R11 done without error");
    // R9 interrupt path
    @(negedge clk);
    drv_irq = 1;
    expect_item(3, 32'h1, "R9 pass high");
    rd(2'd1, 0, 0, 32'h04, "R9 flag on rise");
    @(negedge clk);
    drv_irq = 0;
    expect_item(3, 32'h0, "R9 pass low");
    rd(2'd1, 0, 0, 32'h04, "R9 flag kept on fall");
    wr(2'd1, 0, 0, 32'h04);
    rd(2'd1, 0, 0, 32'h00, "R10 interrupt cleared");
    @(negedge clk);
    drv_irq = 1;
    rd(2'd1, 0, 0, 32'h04, "R9 second rise");
    rd(2'd3, 0, 2, 32'h0, "R2 unused target");
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule